// File: doc/BRIEF.md
# Decode-Stage Hazard and Branch-Freeze Controller

This block controls the decode stage of an in-order, five-stage pipeline that has no operand forwarding. Each cycle it looks at the instruction waiting in the fetch/decode latch. It works out which registers that instruction reads and writes. It checks those registers against a scoreboard of destinations owned by older instructions that have not yet written back. It then either passes the instruction into its single-entry output latch towards execute, or holds it in place.

A read-after-write conflict holds the instruction until the producer's writeback cycle. The register file writes in the first half of a cycle and reads in the second half, so the consumer may leave decode in that same writeback cycle.

A decoded branch moves a two-state controller into a waiting state. In that state fetch is frozen and nothing further is decoded. The freeze holds until execute reports the branch as resolved. On a taken resolution the controller pulses a PC-load strobe with the branch target it computed at decode time. The freeze is released on the following cycle.

Controller states and transitions:
- `ST_RUN` is normal decode.
- `ST_BRWAIT` is the state in which a decoded branch awaits resolution.
- `ST_RUN -> ST_BRWAIT` occurs on the cycle a branch leaves decode.
- `ST_BRWAIT -> ST_RUN` occurs on the cycle execute signals resolution.
- Every other case stays in the current state.

Top module: `hz_decode_ctl`

## Requirements
- R1: After reset the output latch is empty (`ex_valid`=0), fetch is not frozen, `pc_load` is 0, and no register is pending, so the first instruction decoded is accepted in its first cycle.
- R2: Opcode codes on `id_op` are add=0, sub=1, addi=2, mul=3, lw=4, sw=5, beq=6, and 7 is reserved. The reserved code reads and writes nothing. add, sub and mul read `id_rs` and `id_rt` and write `id_rd`. addi and lw read `id_rs` and write `id_rt`. sw and beq read `id_rs` and `id_rt` and write nothing. `ex_dst` is 0 and `ex_wr` is 0 for an instruction that writes no register.
- R3: An accepted instruction appears in the output latch on the next cycle with `ex_valid`=1. The latch carries the opcode and the destination, `ex_a`/`ex_b` equal to the register-file data presented on the accept cycle, and `ex_imm` equal to `id_imm` sign-extended.
- R4: An instruction that reads a register which is pending and is not being written back in that cycle is not accepted, and `id_stall` is 1.
- R5: An instruction whose pending source is written back (`wb_en`, `wb_reg`) in the same cycle is accepted in that cycle.
- R6: Register 0 is never marked pending. An instruction naming register 0 as destination gives `ex_wr`=0, and a later reader of register 0 does not stall.
- R7: An instruction whose destination is still pending and is not being written back that cycle stalls.
- R8: While the output latch is full and `ex_take` is 0, decode stalls and the latch contents are held. With `ex_take`=1 the latch is refilled by a new instruction in the same cycle, or empties when no instruction is accepted.
- R9: `fetch_freeze` is 1 in the cycle a beq is accepted and in every cycle until resolution. No instruction is accepted while the branch waits.
- R10: A resolution (`br_resolved`=1) while waiting drives `pc_load`=`br_taken` in that cycle, with `pc_target` = branch PC+4 + (sign-extended `id_imm` << 2). `fetch_freeze` returns to 0 on the next cycle, when decode resumes.
- R11: `br_resolved` received while no branch is waiting is ignored: `pc_load` stays 0 and fetch is not frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Fetch/decode latch holds an instruction |
| id_op | input | 3 | Opcode code (R2) |
| id_rs | input | RW (5) | First source register field |
| id_rt | input | RW (5) | Second source / immediate-form destination field |
| id_rd | input | RW (5) | Register-form destination field |
| id_imm | input | IMMW (16) | Immediate / branch offset |
| id_pc4 | input | XLEN (32) | Address of the instruction plus 4 |
| rf_rs_addr | output | RW (5) | Register-file read address A |
| rf_rt_addr | output | RW (5) | Register-file read address B |
| rf_rs_data | input | XLEN (32) | Register-file read data A |
| rf_rt_data | input | XLEN (32) | Register-file read data B |
| id_accept | output | 1 | Instruction leaves decode this cycle |
| id_stall | output | 1 | Instruction present but held |
| fetch_freeze | output | 1 | Fetch must not advance |
| ex_valid | output | 1 | Output latch holds an instruction |
| ex_op | output | 3 | Latched opcode |
| ex_dst | output | RW (5) | Latched destination register |
| ex_wr | output | 1 | Latched instruction writes a register |
| ex_a | output | XLEN (32) | Latched operand A |
| ex_b | output | XLEN (32) | Latched operand B |
| ex_imm | output | XLEN (32) | Latched sign-extended immediate |
| ex_take | input | 1 | Execute consumes the output latch this cycle |
| br_resolved | input | 1 | Execute has resolved the waiting branch |
| br_taken | input | 1 | Resolved branch is taken |
| pc_load | output | 1 | Load `pc_target` into the PC |
| pc_target | output | XLEN (32) | Taken-branch target |
| wb_en | input | 1 | Writeback writes a register this cycle |
| wb_reg | input | RW (5) | Register written back |

## Verification
Each opcode code is first issued alone into an idle pipeline. This separates the source and destination selection of each format, including register 0 as destination and the reserved code.

Dependent pairs then distinguish three conflicts: a true read-after-write hold, a write-after-write hold, and a structural hold from a full latch that execute does not drain. Each pair is released on the writeback cycle, which tells the write-first same-cycle release apart from a design that waits one cycle longer.

Taken and not-taken branches with negative and positive offsets check the freeze window, the target arithmetic and the one-cycle release. A stray resolution while running shows that the strobe cannot fire outside the waiting state.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_ADDI = 3'd2,
        OP_MUL  = 3'd3,
        OP_LW   = 3'd4,
        OP_SW   = 3'd5,
        OP_BEQ  = 3'd6,
        OP_RSVD = 3'd7
    } op_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_BRWAIT = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic use_a;
        logic use_b;
        logic wr;
        logic dst_is_rd;
        logic is_br;
    } op_use_t;

    // Source/destination usage per opcode (R2)
    function automatic op_use_t op_usage(input op_e op);
        op_use_t u;
        unique case (op)
            OP_ADD, OP_SUB, OP_MUL: u = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
            OP_ADDI, OP_LW:         u = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
            OP_SW:                  u = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
            OP_BEQ:                 u = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
            OP_RSVD:                u = '0;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/hz_scoreboard.sv
module hz_scoreboard #(
    parameter int NREG = 32,
    parameter int RW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [RW-1:0] set_reg,
    input  logic          wb_en,
    input  logic [RW-1:0] wb_reg,
    input  logic          a_use,
    input  logic [RW-1:0] a_reg,
    input  logic          b_use,
    input  logic [RW-1:0] b_reg,
    input  logic          d_use,
    input  logic [RW-1:0] d_reg,
    output logic          raw_haz,
    output logic          waw_haz
);

    logic [NREG-1:0] pending;
    logic [NREG-1:0] busy;

    // Register 0 never becomes pending
    assign pending[0] = 1'b0;

    genvar g;
    generate
        for (g = 1; g < NREG; g++) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pending[g] <= 1'b0;
                end else if (set_en && set_reg == RW'(g)) begin
                    pending[g] <= 1'b1;
                end else if (wb_en && wb_reg == RW'(g)) begin
                    pending[g] <= 1'b0;
                end
            end
        end
    endgenerate

    // Write-first register file: a register written back this cycle is readable now
    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            busy[i] = pending[i] && !(wb_en && wb_reg == RW'(i));
        end
    end

    assign raw_haz = (a_use && busy[a_reg]) || (b_use && busy[b_reg]);
    assign waw_haz = d_use && busy[d_reg];

endmodule

// File: rtl/hz_branch_fsm.sv
module hz_branch_fsm
    import hz_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            br_issue,
    input  logic [XLEN-1:0] br_target,
    input  logic            br_resolved,
    input  logic            br_taken,
    output logic            br_wait,
    output logic            pc_load,
    output logic [XLEN-1:0] pc_target
);

    ctl_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_target <= '0;
        end else if (br_issue) begin
            pc_target <= br_target;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        br_wait = 1'b0;
        pc_load = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (br_issue) begin
                    state_d = ST_BRWAIT;
                end
            end
            ST_BRWAIT: begin
                br_wait = 1'b1;
                if (br_resolved) begin
                    pc_load = br_taken;
                    state_d = ST_RUN;
                end
            end
        endcase
    end

endmodule

// File: rtl/hz_ex_latch.sv
module hz_ex_latch #(
    parameter int XLEN = 32,
    parameter int RW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            take,
    input  logic [2:0]      in_op,
    input  logic [RW-1:0]   in_dst,
    input  logic            in_wr,
    input  logic [XLEN-1:0] in_a,
    input  logic [XLEN-1:0] in_b,
    input  logic [XLEN-1:0] in_imm,
    output logic            valid,
    output logic [2:0]      op,
    output logic [RW-1:0]   dst,
    output logic            wr,
    output logic [XLEN-1:0] a,
    output logic [XLEN-1:0] b,
    output logic [XLEN-1:0] imm
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
        end else if (take) begin
            valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op  <= '0;
            dst <= '0;
            wr  <= 1'b0;
            a   <= '0;
            b   <= '0;
            imm <= '0;
        end else if (load) begin
            op  <= in_op;
            dst <= in_dst;
            wr  <= in_wr;
            a   <= in_a;
            b   <= in_b;
            imm <= in_imm;
        end
    end

endmodule

// File: rtl/hz_decode_ctl.sv
module hz_decode_ctl
    import hz_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    parameter int IMMW = 16,
    parameter int RW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            id_valid,
    input  logic [2:0]      id_op,
    input  logic [RW-1:0]   id_rs,
    input  logic [RW-1:0]   id_rt,
    input  logic [RW-1:0]   id_rd,
    input  logic [IMMW-1:0] id_imm,
    input  logic [XLEN-1:0] id_pc4,
    output logic [RW-1:0]   rf_rs_addr,
    output logic [RW-1:0]   rf_rt_addr,
    input  logic [XLEN-1:0] rf_rs_data,
    input  logic [XLEN-1:0] rf_rt_data,
    output logic            id_accept,
    output logic            id_stall,
    output logic            fetch_freeze,
    output logic            ex_valid,
    output logic [2:0]      ex_op,
    output logic [RW-1:0]   ex_dst,
    output logic            ex_wr,
    output logic [XLEN-1:0] ex_a,
    output logic [XLEN-1:0] ex_b,
    output logic [XLEN-1:0] ex_imm,
    input  logic            ex_take,
    input  logic            br_resolved,
    input  logic            br_taken,
    output logic            pc_load,
    output logic [XLEN-1:0] pc_target,
    input  logic            wb_en,
    input  logic [RW-1:0]   wb_reg
);

    localparam int SEXT = XLEN - IMMW;

    op_use_t         use_s;
    logic [RW-1:0]   dst_sel;
    logic            wr_eff;
    logic [RW-1:0]   dst_eff;
    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] tgt;
    logic            raw_haz;
    logic            waw_haz;
    logic            br_wait;
    logic            room;

    assign use_s   = op_usage(op_e'(id_op));
    assign dst_sel = use_s.dst_is_rd ? id_rd : id_rt;
    assign wr_eff  = use_s.wr && (dst_sel != '0);
    assign dst_eff = wr_eff ? dst_sel : '0;
    assign imm_sx  = {{SEXT{id_imm[IMMW-1]}}, id_imm};
    assign tgt     = id_pc4 + (imm_sx << 2);

    assign rf_rs_addr = id_rs;
    assign rf_rt_addr = id_rt;

    assign room      = !ex_valid || ex_take;
    assign id_accept = id_valid && !br_wait && !raw_haz && !waw_haz && room;
    assign id_stall  = id_valid && !id_accept;
    assign fetch_freeze = br_wait || (id_accept && use_s.is_br);

    hz_scoreboard #(.NREG(NREG), .RW(RW)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (id_accept && wr_eff),
        .set_reg (dst_eff),
        .wb_en   (wb_en),
        .wb_reg  (wb_reg),
        .a_use   (id_valid && use_s.use_a),
        .a_reg   (id_rs),
        .b_use   (id_valid && use_s.use_b),
        .b_reg   (id_rt),
        .d_use   (id_valid && wr_eff),
        .d_reg   (dst_eff),
        .raw_haz (raw_haz),
        .waw_haz (waw_haz)
    );

    hz_branch_fsm #(.XLEN(XLEN)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .br_issue    (id_accept && use_s.is_br),
        .br_target   (tgt),
        .br_resolved (br_resolved),
        .br_taken    (br_taken),
        .br_wait     (br_wait),
        .pc_load     (pc_load),
        .pc_target   (pc_target)
    );

    hz_ex_latch #(.XLEN(XLEN), .RW(RW)) u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (id_accept),
        .take   (ex_take),
        .in_op  (id_op),
        .in_dst (dst_eff),
        .in_wr  (wr_eff),
        .in_a   (rf_rs_data),
        .in_b   (rf_rt_data),
        .in_imm (imm_sx),
        .valid  (ex_valid),
        .op     (ex_op),
        .dst    (ex_dst),
        .wr     (ex_wr),
        .a      (ex_a),
        .b      (ex_b),
        .imm    (ex_imm)
    );

endmodule

// File: rtl/hz_decode_ctl_chk.sv
module hz_decode_ctl_chk #(
    parameter int RW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          id_accept,
    input logic          id_stall,
    input logic [2:0]    id_op,
    input logic          fetch_freeze,
    input logic          br_wait,
    input logic          ex_valid,
    input logic          ex_take,
    input logic [RW-1:0] ex_dst,
    input logic          ex_wr,
    input logic          pc_load
);

    AST_ACCEPT_XOR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(id_accept && id_stall)); // R4

    AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        id_accept |=> ex_valid); // R3

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !ex_take) |=> (ex_valid && $stable(ex_dst))); // R8

    AST_BRANCH_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (id_accept && id_op == 3'd6) |=> fetch_freeze); // R9

    AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        br_wait |-> (!id_accept && fetch_freeze)); // R9

    AST_LOAD_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> br_wait); // R11

    AST_R0_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_wr) |-> (ex_dst != '0)); // R6

endmodule

bind hz_decode_ctl hz_decode_ctl_chk #(.RW(RW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .id_accept    (id_accept),
    .id_stall     (id_stall),
    .id_op        (id_op),
    .fetch_freeze (fetch_freeze),
    .br_wait      (br_wait),
    .ex_valid     (ex_valid),
    .ex_take      (ex_take),
    .ex_dst       (ex_dst),
    .ex_wr        (ex_wr),
    .pc_load      (pc_load)
);

// File: tb/hz_decode_ctl_tb.sv
module hz_decode_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_valid = 1'b0;
    logic [2:0]  id_op = '0;
    logic [4:0]  id_rs = '0, id_rt = '0, id_rd = '0;
    logic [15:0] id_imm = '0;
    logic [31:0] id_pc4 = '0;
    logic [4:0]  rf_rs_addr, rf_rt_addr;
    logic [31:0] rf_rs_data, rf_rt_data;
    logic        id_accept, id_stall, fetch_freeze;
    logic        ex_valid, ex_wr;
    logic [2:0]  ex_op;
    logic [4:0]  ex_dst;
    logic [31:0] ex_a, ex_b, ex_imm;
    logic        ex_take = 1'b0;
    logic        br_resolved = 1'b0, br_taken = 1'b0;
    logic        pc_load;
    logic [31:0] pc_target;
    logic        wb_en = 1'b0;
    logic [4:0]  wb_reg = '0;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign rf_rs_data = {24'hA00000, 3'b000, rf_rs_addr};
    assign rf_rt_data = {24'hB00000, 3'b000, rf_rt_addr};

    hz_decode_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_op(id_op),
        .id_rs(id_rs), .id_rt(id_rt), .id_rd(id_rd), .id_imm(id_imm),
        .id_pc4(id_pc4), .rf_rs_addr(rf_rs_addr), .rf_rt_addr(rf_rt_addr),
        .rf_rs_data(rf_rs_data), .rf_rt_data(rf_rt_data),
        .id_accept(id_accept), .id_stall(id_stall), .fetch_freeze(fetch_freeze),
        .ex_valid(ex_valid), .ex_op(ex_op), .ex_dst(ex_dst), .ex_wr(ex_wr),
        .ex_a(ex_a), .ex_b(ex_b), .ex_imm(ex_imm), .ex_take(ex_take),
        .br_resolved(br_resolved), .br_taken(br_taken), .pc_load(pc_load),
        .pc_target(pc_target), .wb_en(wb_en), .wb_reg(wb_reg)
    );

    // op[39:37] rs[36:32] rt[31:27] rd[26:22] imm[21:6] exp_dst[5:1] exp_wr[0]
    localparam int NV = 8;
    localparam logic [39:0] VEC [NV] = '{
        {3'd0, 5'd1,  5'd2,  5'd3,  16'h0000, 5'd3,  1'b1},
        {3'd1, 5'd4,  5'd5,  5'd6,  16'h0000, 5'd6,  1'b1},
        {3'd2, 5'd7,  5'd8,  5'd9,  16'hFFFC, 5'd8,  1'b1},
        {3'd3, 5'd10, 5'd11, 5'd12, 16'h0001, 5'd12, 1'b1},
        {3'd4, 5'd13, 5'd14, 5'd0,  16'h0010, 5'd14, 1'b1},
        {3'd5, 5'd15, 5'd16, 5'd17, 16'h8000, 5'd0,  1'b0},
        {3'd0, 5'd1,  5'd2,  5'd0,  16'h0000, 5'd0,  1'b0},
        {3'd7, 5'd3,  5'd4,  5'd5,  16'h7FFF, 5'd0,  1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic instr(input logic v, input logic [2:0] op, input logic [4:0] rs,
                         input logic [4:0] rt, input logic [4:0] rd, input logic [15:0] imm,
                         input logic [31:0] pc4);
        id_valid = v; id_op = op; id_rs = rs; id_rt = rt; id_rd = rd;
        id_imm = imm; id_pc4 = pc4;
    endtask

    task automatic side(input logic take, input logic wbe, input logic [4:0] wbr,
                        input logic res, input logic tk);
        ex_take = take; wb_en = wbe; wb_reg = wbr; br_resolved = res; br_taken = tk;
    endtask

    task automatic edge_settle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog R1: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 ex_valid", {31'b0, ex_valid}, 0);
        check("R1 fetch_freeze", {31'b0, fetch_freeze}, 0);
        check("R1 pc_load", {31'b0, pc_load}, 0);
        check("R1 id_stall idle", {31'b0, id_stall}, 0);

        // Table of single instructions into an idle pipeline (R2, R3, R6)
        for (int i = 0; i < NV; i++) begin
            logic [39:0] v;
            v = VEC[i];
            @(negedge clk);
            instr(1, v[39:37], v[36:32], v[31:27], v[26:22], v[21:6], 32'h0);
            side(1, 0, 0, 0, 0);
            #1;
            check("R1 R2 accept on clean scoreboard", {31'b0, id_accept}, 1);
            edge_settle();
            check("R3 ex_valid", {31'b0, ex_valid}, 1);
            check("R3 ex_op", {29'b0, ex_op}, {29'b0, v[39:37]});
            check("R2 ex_dst", {27'b0, ex_dst}, {27'b0, v[5:1]});
            check("R2 R6 ex_wr", {31'b0, ex_wr}, {31'b0, v[0]});
            check("R3 ex_a", ex_a, {24'hA00000, 3'b000, v[36:32]});
            check("R3 ex_b", ex_b, {24'hB00000, 3'b000, v[31:27]});
            check("R3 ex_imm", ex_imm, {{16{v[21]}}, v[21:6]});
            @(negedge clk);
            instr(0, 0, 0, 0, 0, 0, 0);
            side(1, v[0], v[5:1], 0, 0);
            edge_settle();
        end

        // R4 / R5: read-after-write hold released on writeback cycle
        @(negedge clk);
        instr(1, 3'd0, 5'd1, 5'd2, 5'd5, 0, 0); side(1, 0, 0, 0, 0);
        edge_settle();
        @(negedge clk);
        instr(1, 3'd0, 5'd5, 5'd1, 5'd7, 0, 0); side(1, 0, 0, 0, 0);
        #1;
        check("R4 raw stall", {31'b0, id_stall}, 1);
        check("R4 raw no accept", {31'b0, id_accept}, 0);
        edge_settle();
        @(negedge clk);
        side(1, 0, 0, 0, 0);
        #1;
        check("R4 raw still held", {31'b0, id_stall}, 1);
        edge_settle();
        @(negedge clk);
        side(1, 1, 5'd5, 0, 0);
        #1;
        check("R5 same-cycle writeback release", {31'b0, id_accept}, 1);
        edge_settle();
        check("R5 released instr dst", {27'b0, ex_dst}, 7);
        @(negedge clk);
        instr(0, 0, 0, 0, 0, 0, 0); side(1, 1, 5'd7, 0, 0);
        edge_settle();

        // R6: register 0 reader after register 0 writer
        @(negedge clk);
        instr(1, 3'd0, 5'd1, 5'd2, 5'd0, 0, 0); side(1, 0, 0, 0, 0);
        edge_settle();
        check("R6 r0 dst not written", {31'b0, ex_wr}, 0);
        @(negedge clk);
        instr(1, 3'd0, 5'd0, 5'd0, 5'd9, 0, 0); side(1, 0, 0, 0, 0);
        #1;
        check("R6 r0 reader accepted", {31'b0, id_accept}, 1);
        edge_settle();
        @(negedge clk);
        instr(0, 0, 0, 0, 0, 0, 0); side(1, 1, 5'd9, 0, 0);
        edge_settle();

        // R7: write-after-write hold
        @(negedge clk);
        instr(1, 3'd4, 5'd1, 5'd20, 5'd0, 0, 0); side(1, 0, 0, 0, 0);
        edge_settle();
        @(negedge clk);
        instr(1, 3'd0, 5'd1, 5'd2, 5'd20, 0, 0); side(1, 0, 0, 0, 0);
        #1;
        check("R7 waw stall", {31'b0, id_stall}, 1);
        edge_settle();
        @(negedge clk);
        side(1, 1, 5'd20, 0, 0);
        #1;
        check("R7 waw release", {31'b0, id_accept}, 1);
        edge_settle();
        @(negedge clk);
        instr(0, 0, 0, 0, 0, 0, 0); side(1, 1, 5'd20, 0, 0);
        edge_settle();

        // R8: full output latch
        @(negedge clk);
        instr(1, 3'd0, 5'd1, 5'd2, 5'd21, 0, 0); side(0, 0, 0, 0, 0);
        edge_settle();
        @(negedge clk);
        instr(1, 3'd0, 5'd3, 5'd4, 5'd22, 0, 0); side(0, 0, 0, 0, 0);
        #1;
        check("R8 full latch stall", {31'b0, id_stall}, 1);
        edge_settle();
        check("R8 latch held valid", {31'b0, ex_valid}, 1);
        check("R8 latch held dst", {27'b0, ex_dst}, 21);
        @(negedge clk);
        side(1, 0, 0, 0, 0);
        #1;
        check("R8 refill accept", {31'b0, id_accept}, 1);
        edge_settle();
        check("R8 refilled dst", {27'b0, ex_dst}, 22);
        @(negedge clk);
        instr(0, 0, 0, 0, 0, 0, 0); side(1, 1, 5'd21, 0, 0);
        edge_settle();
        check("R8 drained", {31'b0, ex_valid}, 0);
        @(negedge clk);
        side(1, 1, 5'd22, 0, 0);
        edge_settle();

        // R9 / R10: taken branch, negative offset
        @(negedge clk);
        instr(1, 3'd6, 5'd1, 5'd2, 5'd0, 16'hFFFF, 32'h100); side(1, 0, 0, 0, 0);
        #1;
        check("R9 beq accepted", {31'b0, id_accept}, 1);
        check("R9 freeze on accept", {31'b0, fetch_freeze}, 1);
        edge_settle();
        check("R9 beq in latch", {29'b0, ex_op}, 6);
        check("R2 beq no write", {31'b0, ex_wr}, 0);
        @(negedge clk);
        instr(1, 3'd0, 5'd1, 5'd2, 5'd23, 0, 0); side(1, 0, 0, 0, 0);
        #1;
        check("R9 frozen no decode", {31'b0, id_accept}, 0);
        check("R9 freeze held", {31'b0, fetch_freeze}, 1);
        edge_settle();
        @(negedge clk);
        side(1, 0, 0, 1, 1);
        #1;
        check("R10 pc_load on taken", {31'b0, pc_load}, 1);
        check("R10 target", pc_target, 32'h0000_00FC);
        check("R10 freeze during resolve", {31'b0, fetch_freeze}, 1);
        edge_settle();
        @(negedge clk);
        side(1, 0, 0, 0, 0);
        #1;
        check("R10 freeze lifted", {31'b0, fetch_freeze}, 0);
        check("R10 pc_load dropped", {31'b0, pc_load}, 0);
        check("R10 decode resumes", {31'b0, id_accept}, 1);
        edge_settle();
        @(negedge clk);
        instr(0, 0, 0, 0, 0, 0, 0); side(1, 1, 5'd23, 0, 0);
        edge_settle();

        // R10: not-taken branch, positive offset
        @(negedge clk);
        instr(1, 3'd6, 5'd3, 5'd4, 5'd0, 16'h0004, 32'h200); side(1, 0, 0, 0, 0);
        edge_settle();
        @(negedge clk);
        instr(0, 0, 0, 0, 0, 0, 0); side(1, 0, 0, 1, 0);
        #1;
        check("R10 not taken no load", {31'b0, pc_load}, 0);
        check("R10 target positive", pc_target, 32'h0000_0210);
        edge_settle();
        @(negedge clk);
        side(1, 0, 0, 0, 0);
        #1;
        check("R10 not taken freeze lifted", {31'b0, fetch_freeze}, 0);

        // R11: stray resolution while running
        @(negedge clk);
        side(1, 0, 0, 1, 1);
        #1;
        check("R11 stray resolve no load", {31'b0, pc_load}, 0);
        check("R11 stray resolve no freeze", {31'b0, fetch_freeze}, 0);
        edge_settle();
        @(negedge clk);
        side(1, 0, 0, 0, 0);
        #1;
        check("R11 still running", {31'b0, fetch_freeze}, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule